// File: doc/BRIEF.md
# Low-Voltage Detect Status and Control Register

This block holds one 8-bit status and control register for a supply-voltage monitor. A comparator elsewhere on the chip reports a low-supply condition on an asynchronous input. A two-flop synchronizer brings that input into the clock domain. The synchronized level sets a sticky event flag, and the flag stays set until software acknowledges it. From the flag, the block drives an interrupt request and a device-reset request, each behind its own enable. The register also supplies a two-bit threshold select that goes back to the comparator.

Software reaches the register over a plain single-register bus:
- `bus_sel` selects the register.
- `bus_wr` strikes a write.
- `bus_wdata` carries the write data.
- `bus_rdata` returns the register image, and is zero while the register is not selected.

No data streams through this block, so it has no valid/ready handshake. Every pin is plain control or status. While the `low_power_i` input is high, detection is held off.

Top module: `lvd_ctrl_reg`

## Requirements
- R1: The event flag (read bit 7) becomes 1 on a detected low-voltage event. It then holds 1 until an acknowledge write, even after the detect input returns to 0.
- R2: A write with data bit 6 set clears the event flag on the following clock edge. Bit 6 always reads as 0.
- R3: `irq_o` is 1 exactly when the event flag is 1 and the interrupt enable (bit 5, reset value 0) is 1.
- R4: `reset_req_o` is 1 exactly when the event flag is 1 and the reset enable (bit 4, reset value 1) is 1.
- R5: The first write after reset may change the reset enable. That first write locks it, whether or not the value changed. Every later write leaves the reset enable unchanged until the next reset.
- R6: Bits 3 and 2 always read as 0.
- R7: Bits 1:0 store the threshold select written by software and drive `trip_sel_o`. Code 00 selects the low threshold and 01 the high threshold.
- R8: After reset the register reads 0x10, and both `irq_o` and `reset_req_o` are 0.
- R9: While `low_power_i` is 1, no detect level can set the event flag.
- R10: If a detect level and an acknowledge write arrive in the same cycle, the flag stays 1.
- R11: The flag rises on the third rising clock edge after the detect input goes high, because the input passes through two synchronizer stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register select |
| bus_wr | input | 1 | Write strobe, qualified by `bus_sel` |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, zero when not selected |
| lv_detect_i | input | 1 | Asynchronous low-voltage level from the comparator |
| low_power_i | input | 1 | High while the device is in a low-power mode |
| irq_o | output | 1 | Interrupt request |
| reset_req_o | output | 1 | Device reset request |
| trip_sel_o | output | 2 | Threshold select to the comparator |

## Verification
Several properties are checked on every cycle:
- the flag holds, and an acknowledge clears it;
- a detect level wins over a simultaneous acknowledge;
- detection is blocked in low-power mode;
- the interrupt and reset requests agree with the read image;
- the reserved and acknowledge bits read as zero;
- the reset enable stays frozen once locked.

Only the bench's scenarios can show the reset image, the exact synchronizer latency counted from the raw pin, and that a second write really leaves the reset enable alone. They also show that the threshold code round-trips to `trip_sel_o`.

// File: rtl/lvd_pkg.sv
package lvd_pkg;
  localparam int REG_W    = 8;
  localparam int FLAG_BIT = 7;
  localparam int ACK_BIT  = 6;
  localparam int IE_BIT   = 5;
  localparam int RE_BIT   = 4;
  localparam int TRIP_LSB = 0;
  localparam int TRIP_W   = 2;
  localparam int SYNC_N   = 2;

  typedef struct packed {
    logic              irq_en;
    logic              rst_en;
    logic [TRIP_W-1:0] trip;
  } lvd_ctl_t;
endpackage

// File: rtl/lvd_sync.sv
module lvd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= async_i;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/lvd_flag.sv
module lvd_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  input  logic gate_off_i,
  input  logic ack_i,
  output logic flag_o
);
  logic set_ev;

  // A qualified event has priority over an acknowledge.
  assign set_ev = level_i && !gate_off_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag_o <= 1'b0;
    else if (set_ev) flag_o <= 1'b1;
    else if (ack_i)  flag_o <= 1'b0;
  end
endmodule

// File: rtl/lvd_ctl.sv
module lvd_ctl
  import lvd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  output lvd_ctl_t         ctl_o,
  output logic             locked_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_o.irq_en <= 1'b0;
      ctl_o.rst_en <= 1'b1;
      ctl_o.trip   <= '0;
      locked_o     <= 1'b0;
    end else if (wr_i) begin
      ctl_o.irq_en <= wdata_i[IE_BIT];
      ctl_o.trip   <= wdata_i[TRIP_LSB +: TRIP_W];
      if (!locked_o) ctl_o.rst_en <= wdata_i[RE_BIT];
      locked_o     <= 1'b1;
    end
  end
endmodule

// File: rtl/lvd_ctrl_reg.sv
module lvd_ctrl_reg
  import lvd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              lv_detect_i,
  input  logic              low_power_i,
  output logic              irq_o,
  output logic              reset_req_o,
  output logic [TRIP_W-1:0] trip_sel_o
);
  logic     det_sync;
  logic     flag;
  logic     wr_hit;
  logic     ack_hit;
  logic     locked;
  lvd_ctl_t ctl;

  assign wr_hit  = bus_sel && bus_wr;
  assign ack_hit = wr_hit && bus_wdata[ACK_BIT];

  lvd_sync #(.STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(lv_detect_i), .sync_o(det_sync)
  );

  lvd_flag u_flag (
    .clk(clk), .rst_n(rst_n), .level_i(det_sync), .gate_off_i(low_power_i),
    .ack_i(ack_hit), .flag_o(flag)
  );

  lvd_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .wr_i(wr_hit), .wdata_i(bus_wdata),
    .ctl_o(ctl), .locked_o(locked)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_sel) begin
      bus_rdata[FLAG_BIT]                 = flag;
      bus_rdata[IE_BIT]                   = ctl.irq_en;
      bus_rdata[RE_BIT]                   = ctl.rst_en;
      bus_rdata[TRIP_LSB +: TRIP_W]       = ctl.trip;
    end
  end

  assign irq_o       = flag && ctl.irq_en;
  assign reset_req_o = flag && ctl.rst_en;
  assign trip_sel_o  = ctl.trip;
endmodule

// File: rtl/lvd_ctrl_reg_chk.sv
module lvd_ctrl_reg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_sel,
  input logic       bus_wr,
  input logic [7:0] bus_wdata,
  input logic [7:0] bus_rdata,
  input logic       low_power_i,
  input logic       irq_o,
  input logic       reset_req_o,
  input logic       flag,
  input logic       det_sync,
  input logic       rst_en,
  input logic       locked
);
  logic ack_w;
  assign ack_w = bus_sel && bus_wr && bus_wdata[6];

  // R1
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !ack_w) |=> flag);

  // R2
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_w && (!det_sync || low_power_i)) |=> !flag);

  // R3
  irq_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel |-> (irq_o == (bus_rdata[7] && bus_rdata[5])));

  // R4
  rst_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel |-> (reset_req_o == (bus_rdata[7] && bus_rdata[4])));

  // R5
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(rst_en));

  // R6
  zero_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata[6] == 1'b0) && (bus_rdata[3:2] == 2'b00));

  // R9
  low_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (low_power_i && !flag) |=> !flag);

  // R10
  event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (det_sync && !low_power_i) |=> flag);
endmodule

bind lvd_ctrl_reg lvd_ctrl_reg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .low_power_i(low_power_i),
  .irq_o(irq_o), .reset_req_o(reset_req_o), .flag(flag), .det_sync(det_sync),
  .rst_en(ctl.rst_en), .locked(locked)
);

// File: tb/test_lvd_ctrl_reg.sv
`timescale 1ns/1ps
module test_lvd_ctrl_reg;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b1;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       lv_detect_i = 1'b0;
  logic       low_power_i = 1'b0;
  logic       irq_o;
  logic       reset_req_o;
  logic [1:0] trip_sel_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  lvd_ctrl_reg i_lvd_ctrl_reg (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lv_detect_i(lv_detect_i),
    .low_power_i(low_power_i), .irq_o(irq_o), .reset_req_o(reset_req_o),
    .trip_sel_o(trip_sel_o)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; bus_wr = 1'b0; lv_detect_i = 1'b0; low_power_i = 1'b0;
    cycles(2);
    rst_n = 1'b1;
    cycles(1);
  endtask

  task automatic reg_write(input logic [7:0] d);
    bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic t_reset_state();
    do_reset();
    check("R8 image", bus_rdata, 8'h10);
    check("R8 irq", {7'd0, irq_o}, 8'h0);
    check("R8 rst_req", {7'd0, reset_req_o}, 8'h0);
    check("R7 trip reset", {6'd0, trip_sel_o}, 8'h0);
  endtask

  task automatic t_write_once();
    do_reset();
    reg_write(8'h21);
    check("R5 first write clears rst_en", bus_rdata, 8'h21);
    check("R7 trip high", {6'd0, trip_sel_o}, 8'h1);
    reg_write(8'h1E);
    check("R5 second write ignored, R6 reserved zero", bus_rdata, 8'h02);
    check("R7 trip code 10", {6'd0, trip_sel_o}, 8'h2);
  endtask

  task automatic t_detect_irq();
    do_reset();
    reg_write(8'h20);
    lv_detect_i = 1'b1;
    cycles(2);
    check("R11 not yet after two edges", {7'd0, bus_rdata[7]}, 8'h0);
    cycles(1);
    check("R11 flag on third edge", {7'd0, bus_rdata[7]}, 8'h1);
    check("R3 irq", {7'd0, irq_o}, 8'h1);
    check("R4 no rst_req when disabled", {7'd0, reset_req_o}, 8'h0);
    lv_detect_i = 1'b0;
    cycles(5);
    check("R1 sticky", bus_rdata, 8'hA0);
    reg_write(8'h60);
    check("R2 ack clears, bit6 reads 0", bus_rdata, 8'h20);
    check("R3 irq drops", {7'd0, irq_o}, 8'h0);
  endtask

  task automatic t_reset_request();
    do_reset();
    lv_detect_i = 1'b1;
    cycles(3);
    lv_detect_i = 1'b0;
    check("R4 flag with default rst_en", bus_rdata, 8'h90);
    check("R4 rst_req", {7'd0, reset_req_o}, 8'h1);
    check("R3 no irq when disabled", {7'd0, irq_o}, 8'h0);
    cycles(3);
    reg_write(8'h50);
    check("R2 ack keeps rst_en", bus_rdata, 8'h10);
    check("R4 rst_req drops", {7'd0, reset_req_o}, 8'h0);
  endtask

  task automatic t_low_power();
    do_reset();
    low_power_i = 1'b1;
    lv_detect_i = 1'b1;
    cycles(6);
    check("R9 gated", {7'd0, bus_rdata[7]}, 8'h0);
    low_power_i = 1'b0;
    cycles(1);
    check("R9 resumes after gate", {7'd0, bus_rdata[7]}, 8'h1);
    lv_detect_i = 1'b0;
    cycles(3);
  endtask

  task automatic t_race();
    do_reset();
    lv_detect_i = 1'b1;
    cycles(4);
    reg_write(8'h40);
    check("R10 event wins over ack", {7'd0, bus_rdata[7]}, 8'h1);
    lv_detect_i = 1'b0;
    cycles(3);
    reg_write(8'h40);
    check("R2 ack after level gone", {7'd0, bus_rdata[7]}, 8'h0);
    bus_sel = 1'b0;
    #1;
    check("R6 unselected reads zero", bus_rdata, 8'h0);
    bus_sel = 1'b1;
  endtask

  initial begin
    t_reset_state();
    t_write_once();
    t_detect_irq();
    t_reset_request();
    t_low_power();
    t_race();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule